// File: doc/BRIEF.md
# LCD Panel Timing and AC-Bias Generator

This block turns a single core clock into the control waveforms a raster LCD panel needs: a dot clock, a one-cycle data strobe that marks when pixel data must change, horizontal and vertical sync, a data-enable window and an AC-bias signal. The AC-bias signal lets the panel reverse its drive polarity so that the liquid crystal never sits under a constant DC field. All settings arrive as static configuration inputs. A register file elsewhere is expected to hold them, and the block is reset after any of them is changed.

The dot clock comes from a divide-by-2×(D+1) toggle counter, or it is the core clock itself when the bypass input is set. The data strobe fires in the core cycle that ends with the chosen dot-clock edge, and each strobe moves the horizontal counter forward by one dot. The horizontal counter steps through sync, back porch, active and front porch segments. Each time it wraps, the vertical counter, which has the same four segments, moves forward by one line. The AC-bias output either flips once per frame, or flips after a programmable number of line-sync pulses, counted afresh from the start of every frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst` is high and after its release, before the first strobe, `hsync` and `vsync` read 1 (both counters start in their sync segment), `den` reads 0, `ac_mod` reads 0 and, when not bypassed, `dot_clk` reads 0.
- R2: With `div_bypass`=0, `dot_clk` has a period of 2×(`div_val`+1) core cycles and stays high for `div_val`+1 of them.
- R3: With `div_bypass`=1, `dot_clk` follows the core clock and `data_launch` is 1 in every core cycle.
- R4: With `div_bypass`=0, `data_launch` is high for exactly the core cycle that ends with a falling `dot_clk` edge when `rise_sel`=0, or with a rising edge when `rise_sel`=1.
- R5: Sync levels are active high. Both sync outputs change only one cycle after a strobe. A line lasts `hs_width`+`hbp_width`+`hact_width`+`hfp_width` dot periods, and `hsync` is high for `hs_width` of them.
- R6: A frame lasts `vs_width`+`vbp_width`+`vact_width`+`vfp_width` lines. `vsync` is high for `vs_width` whole lines, and it rises on the same edge as `hsync`.
- R7: `den` is high only in the active segment of both counters, giving `hact_width` dot periods per line and `vact_width` pulses per frame.
- R8: With `mod_line_mode`=0, `ac_mod` inverts at the start of every frame.
- R9: With `mod_line_mode`=1, `ac_mod` inverts at the start of every (`mod_pulses`+1)-th line-sync pulse, counted from 1 at the pulse that opens each frame. The count restarts every frame, so when (`mod_pulses`+1) exceeds the lines per frame, `ac_mod` never changes. The pulse already present at reset counts as pulse 1 but causes no inversion.
- R10: A segment width of 0 acts as a width of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Dot-clock divisor D |
| div_bypass | input | 1 | 1: dot clock is the core clock |
| rise_sel | input | 1 | 1: data changes on the rising dot-clock edge |
| mod_line_mode | input | 1 | 0: AC bias per frame, 1: per line-sync count |
| mod_pulses | input | MVAL_W | Line-sync pulses per AC-bias half period, minus one |
| hs_width | input | CNT_W | Horizontal sync width in dots |
| hbp_width | input | CNT_W | Horizontal back porch in dots |
| hact_width | input | CNT_W | Active dots per line |
| hfp_width | input | CNT_W | Horizontal front porch in dots |
| vs_width | input | CNT_W | Vertical sync width in lines |
| vbp_width | input | CNT_W | Vertical back porch in lines |
| vact_width | input | CNT_W | Active lines per frame |
| vfp_width | input | CNT_W | Vertical front porch in lines |
| dot_clk | output | 1 | Panel dot clock |
| data_launch | output | 1 | One-cycle strobe: pixel data changes now |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| den | output | 1 | Data enable |
| ac_mod | output | 1 | AC-bias output |

## Verification
In line-count mode, a frame length that is not a multiple of the pulse count exposes a pulse counter that skips its restart at frame start: across each frame boundary the bench expects a longer toggle gap, which such a counter would not produce. With a pulse count larger than the frame, the bench expects no toggle at all; a counter that never restarts would still toggle, slowly. Comparing the strobe against the dot-clock level on both edge settings catches a swapped edge select, which would shift data by half a dot. A configuration with zero-width porches catches a counter that reads 0 as 2^N or stalls, either of which would change the line and frame periods.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    typedef struct packed {
        logic sync;
        logic active;
        logic wrap;
    } seg_stat_t;

    function automatic seg_e seg_next(seg_e cur);
        case (cur)
            SEG_SYNC:   return SEG_BACK;
            SEG_BACK:   return SEG_ACTIVE;
            SEG_ACTIVE: return SEG_FRONT;
            default:    return SEG_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lcdt_dotclk.sv
module lcdt_dotclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             bypass,
    input  logic             rise_sel,
    output logic             dclk_q,
    output logic             launch
);
    logic [DIV_W-1:0] cnt;
    logic             term;

    // terminal count ends each half period of the divided clock
    assign term   = !bypass && (cnt >= div_val);
    // strobe in the cycle whose closing edge produces the chosen transition
    assign launch = bypass || (term && (dclk_q != rise_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dclk_q <= 1'b0;
        end else if (bypass) begin
            cnt    <= '0;
            dclk_q <= 1'b0;
        end else if (term) begin
            cnt    <= '0;
            dclk_q <= ~dclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcdt_segctr.sv
module lcdt_segctr
    import lcdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [3:0][CNT_W-1:0] seg_len,
    output seg_stat_t             stat
);
    localparam int XW = CNT_W + 1;

    seg_e             ph;
    logic [CNT_W-1:0] cnt;
    logic [XW-1:0]    len_x;
    logic [XW-1:0]    pos_x;
    logic             last;

    // a zero length ends the segment after one unit, same as a length of 1
    assign len_x = {1'b0, seg_len[ph]};
    assign pos_x = {1'b0, cnt} + XW'(1);
    assign last  = (pos_x >= len_x);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= SEG_SYNC;
            cnt <= '0;
        end else if (adv) begin
            if (last) begin
                cnt <= '0;
                ph  <= seg_next(ph);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        stat.sync   = (ph == SEG_SYNC);
        stat.active = (ph == SEG_ACTIVE);
        stat.wrap   = adv && last && (ph == SEG_FRONT);
    end
endmodule

// File: rtl/lcdt_acbias.sv
module lcdt_acbias #(
    parameter int MVAL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic              line_mode,
    input  logic [MVAL_W-1:0] mod_pulses,
    output logic              ac_mod
);
    localparam int PW = MVAL_W + 1;

    logic [PW-1:0] pulses;
    logic [PW-1:0] base;
    logic [PW-1:0] nxt;
    logic [PW-1:0] limit;

    // pulse that opens a frame is number 1 of that frame
    assign base  = frame_start ? '0 : pulses;
    assign nxt   = base + PW'(1);
    assign limit = {1'b0, mod_pulses} + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses <= PW'(1);
            ac_mod <= 1'b0;
        end else if (line_start) begin
            if (line_mode) begin
                if (nxt >= limit) begin
                    ac_mod <= ~ac_mod;
                    pulses <= '0;
                end else begin
                    pulses <= nxt;
                end
            end else begin
                pulses <= nxt;
                if (frame_start) begin
                    ac_mod <= ~ac_mod;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 10,
    parameter int MVAL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              div_bypass,
    input  logic              rise_sel,
    input  logic              mod_line_mode,
    input  logic [MVAL_W-1:0] mod_pulses,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic [CNT_W-1:0]  hbp_width,
    input  logic [CNT_W-1:0]  hact_width,
    input  logic [CNT_W-1:0]  hfp_width,
    input  logic [CNT_W-1:0]  vs_width,
    input  logic [CNT_W-1:0]  vbp_width,
    input  logic [CNT_W-1:0]  vact_width,
    input  logic [CNT_W-1:0]  vfp_width,
    output logic              dot_clk,
    output logic              data_launch,
    output logic              hsync,
    output logic              vsync,
    output logic              den,
    output logic              ac_mod
);
    logic                  dclk_q;
    seg_stat_t             hstat;
    seg_stat_t             vstat;
    logic [3:0][CNT_W-1:0] hlen;
    logic [3:0][CNT_W-1:0] vlen;
    logic                  frame_start;

    // index order follows the segment encoding: sync, back, active, front
    assign hlen = {hfp_width, hact_width, hbp_width, hs_width};
    assign vlen = {vfp_width, vact_width, vbp_width, vs_width};

    lcdt_dotclk #(.DIV_W(DIV_W)) u_dot (
        .clk      (clk),
        .rst      (rst),
        .div_val  (div_val),
        .bypass   (div_bypass),
        .rise_sel (rise_sel),
        .dclk_q   (dclk_q),
        .launch   (data_launch)
    );

    lcdt_segctr #(.CNT_W(CNT_W)) u_hctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (data_launch),
        .seg_len (hlen),
        .stat    (hstat)
    );

    lcdt_segctr #(.CNT_W(CNT_W)) u_vctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (hstat.wrap),
        .seg_len (vlen),
        .stat    (vstat)
    );

    assign frame_start = hstat.wrap && vstat.wrap;

    lcdt_acbias #(.MVAL_W(MVAL_W)) u_bias (
        .clk         (clk),
        .rst         (rst),
        .line_start  (hstat.wrap),
        .frame_start (frame_start),
        .line_mode   (mod_line_mode),
        .mod_pulses  (mod_pulses),
        .ac_mod      (ac_mod)
    );

    assign dot_clk = div_bypass ? clk : dclk_q;
    assign hsync   = hstat.sync;
    assign vsync   = vstat.sync;
    assign den     = hstat.active && vstat.active;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk (
    input logic clk,
    input logic rst,
    input logic div_bypass,
    input logic data_launch,
    input logic dclk_q,
    input logic hsync,
    input logic vsync,
    input logic den,
    input logic ac_mod
);
    AST_DEN_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (rst)
        den |-> (!hsync && !vsync)); // R7

    AST_BYPASS_STROBE: assert property (@(posedge clk) disable iff (rst)
        div_bypass |-> data_launch); // R3

    AST_STROBE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (data_launch && !div_bypass) |=> (dclk_q != $past(dclk_q))); // R4

    AST_HSYNC_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (hsync != $past(hsync)) |-> $past(data_launch)); // R5

    AST_VSYNC_WITH_HSYNC: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> $rose(hsync)); // R6

    AST_MOD_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
        (ac_mod != $past(ac_mod)) |-> $rose(hsync)); // R9
endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_bypass  (div_bypass),
    .data_launch (data_launch),
    .dclk_q      (dclk_q),
    .hsync       (hsync),
    .vsync       (vsync),
    .den         (den),
    .ac_mod      (ac_mod)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_val = '0;
    logic       div_bypass = 1'b0;
    logic       rise_sel = 1'b0;
    logic       mod_line_mode = 1'b0;
    logic [7:0] mod_pulses = '0;
    logic [9:0] hs_width = 10'd1, hbp_width = 10'd1, hact_width = 10'd1, hfp_width = 10'd1;
    logic [9:0] vs_width = 10'd1, vbp_width = 10'd1, vact_width = 10'd1, vfp_width = 10'd1;
    logic dot_clk, data_launch, hsync, vsync, den, ac_mod;

    always #2.5 clk = ~clk;

    lcd_timing_gen uut (
        .clk(clk), .rst(rst), .div_val(div_val), .div_bypass(div_bypass),
        .rise_sel(rise_sel), .mod_line_mode(mod_line_mode), .mod_pulses(mod_pulses),
        .hs_width(hs_width), .hbp_width(hbp_width), .hact_width(hact_width),
        .hfp_width(hfp_width), .vs_width(vs_width), .vbp_width(vbp_width),
        .vact_width(vact_width), .vfp_width(vfp_width), .dot_clk(dot_clk),
        .data_launch(data_launch), .hsync(hsync), .vsync(vsync), .den(den),
        .ac_mod(ac_mod)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    string note = "";

    // expected items, pushed by the driver and consumed by the monitor
    int q_hper[$], q_hwid[$], q_vper[$], q_vwid[$], q_dwid[$], q_dcnt[$], q_mod[$];
    int exp_div = 0;
    bit exp_byp = 1'b0;
    bit exp_rise = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, note, act, exp);
        end
    endtask

    // monitor state
    int cyc, last_hr, last_vr, last_dr, last_der, last_m, den_cnt, mod_chg;
    bit have_hr, have_vr, have_dr, have_der, have_m, pend_edge;
    logic p_h, p_v, p_d, p_de, p_m;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; have_hr = 0; have_vr = 0; have_dr = 0; have_der = 0;
            have_m = 0; pend_edge = 0; den_cnt = 0; mod_chg = 0;
        end else begin
            int e;
            cyc++;
            if (hsync && !p_h) begin
                if (have_hr && q_hper.size() > 0) begin
                    e = q_hper.pop_front(); chk(cyc - last_hr == e, "R5 line period", cyc - last_hr, e);
                end
                last_hr = cyc; have_hr = 1;
            end
            if (!hsync && p_h && have_hr && q_hwid.size() > 0) begin
                e = q_hwid.pop_front(); chk(cyc - last_hr == e, "R5 hsync width", cyc - last_hr, e);
            end
            if (vsync && !p_v) begin
                if (have_vr && q_vper.size() > 0) begin
                    e = q_vper.pop_front(); chk(cyc - last_vr == e, "R6 frame period", cyc - last_vr, e);
                end
                if (q_dcnt.size() > 0) begin
                    e = q_dcnt.pop_front(); chk(den_cnt == e, "R7 den pulses per frame", den_cnt, e);
                end
                den_cnt = 0; last_vr = cyc; have_vr = 1;
            end
            if (!vsync && p_v && have_vr && q_vwid.size() > 0) begin
                e = q_vwid.pop_front(); chk(cyc - last_vr == e, "R6 vsync width", cyc - last_vr, e);
            end
            if (den && !p_de) begin
                den_cnt++; last_der = cyc; have_der = 1;
            end
            if (!den && p_de && have_der && q_dwid.size() > 0) begin
                e = q_dwid.pop_front(); chk(cyc - last_der == e, "R7 den width", cyc - last_der, e);
            end
            if (ac_mod != p_m) begin
                mod_chg++;
                if (have_m && q_mod.size() > 0) begin
                    e = q_mod.pop_front(); chk(cyc - last_m == e, "R8/R9 ac_mod interval", cyc - last_m, e);
                end
                last_m = cyc; have_m = 1;
            end
            if (!exp_byp) begin
                if (pend_edge) begin
                    chk(dot_clk == exp_rise, "R4 edge after strobe", int'(dot_clk), int'(exp_rise));
                    pend_edge = 0;
                end
                if (data_launch) begin
                    chk(dot_clk == !exp_rise, "R4 level at strobe", int'(dot_clk), int'(!exp_rise));
                    pend_edge = 1;
                end
                if (dot_clk && !p_d) begin
                    if (have_dr) chk(cyc - last_dr == 2 * (exp_div + 1), "R2 dot period", cyc - last_dr, 2 * (exp_div + 1));
                    last_dr = cyc; have_dr = 1;
                end
                if (!dot_clk && p_d && have_dr)
                    chk(cyc - last_dr == exp_div + 1, "R2 dot high time", cyc - last_dr, exp_div + 1);
            end
        end
        p_h = hsync; p_v = vsync; p_d = dot_clk; p_de = den; p_m = ac_mod;
    end

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic run_cfg(input int dv, input bit byp, input bit rs, input bit mm, input int mp,
                           input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf,
                           input int nf, input string tag);
        int p, l, vl;
        int lines[$];
        @(posedge clk); #1;
        rst = 1'b1;
        div_val = dv[7:0]; div_bypass = byp; rise_sel = rs; mod_line_mode = mm; mod_pulses = mp[7:0];
        hs_width = hs[9:0]; hbp_width = hb[9:0]; hact_width = ha[9:0]; hfp_width = hf[9:0];
        vs_width = vs[9:0]; vbp_width = vb[9:0]; vact_width = va[9:0]; vfp_width = vf[9:0];
        exp_div = dv; exp_byp = byp; exp_rise = rs; note = tag;
        q_hper.delete(); q_hwid.delete(); q_vper.delete(); q_vwid.delete();
        q_dwid.delete(); q_dcnt.delete(); q_mod.delete();
        p  = byp ? 1 : 2 * (dv + 1);
        l  = (eff(hs) + eff(hb) + eff(ha) + eff(hf)) * p;
        vl = eff(vs) + eff(vb) + eff(va) + eff(vf);
        repeat (nf * vl - 2) q_hper.push_back(l);
        repeat (nf * vl - vl) q_hwid.push_back(eff(hs) * p);
        repeat (nf - 2) q_vper.push_back(vl * l);
        repeat (nf - 2) q_vwid.push_back(eff(vs) * l);
        repeat (eff(va) * (nf - 1)) q_dwid.push_back(eff(ha) * p);
        repeat (nf - 1) q_dcnt.push_back(eff(va));
        if (!mm) begin
            repeat (nf - 2) q_mod.push_back(vl * l);
        end else begin
            for (int f = 0; f < nf; f++)
                for (int k = 1; k <= vl; k++)
                    if ((k % (mp + 1)) == 0 && !(f == 0 && k == 1)) lines.push_back(f * vl + k - 1);
            for (int i = 1; i < lines.size(); i++) q_mod.push_back((lines[i] - lines[i-1]) * l);
        end
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        chk(hsync == 1'b1, "R1 hsync in reset", int'(hsync), 1);
        chk(vsync == 1'b1, "R1 vsync in reset", int'(vsync), 1);
        chk(den == 1'b0, "R1 den in reset", int'(den), 0);
        chk(ac_mod == 1'b0, "R1 ac_mod in reset", int'(ac_mod), 0);
        if (!byp) chk(dot_clk == 1'b0, "R1 dot_clk in reset", int'(dot_clk), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        if (byp) begin
            // R3: dot clock follows the core clock, strobe every cycle
            repeat (6) begin
                @(posedge clk); #1;
                chk(dot_clk == 1'b1, "R3 dot_clk high phase", int'(dot_clk), 1);
                chk(data_launch == 1'b1, "R3 strobe every cycle", int'(data_launch), 1);
                @(negedge clk); #1;
                chk(dot_clk == 1'b0, "R3 dot_clk low phase", int'(dot_clk), 0);
            end
        end
        repeat (nf * vl * l + 4 * p + 20) @(posedge clk);
        chk(q_hper.size() == 0, "R5 line events missing", q_hper.size(), 0);
        chk(q_hwid.size() == 0, "R5 hsync widths missing", q_hwid.size(), 0);
        chk(q_vper.size() == 0, "R6 frame events missing", q_vper.size(), 0);
        chk(q_vwid.size() == 0, "R6 vsync widths missing", q_vwid.size(), 0);
        chk(q_dwid.size() == 0, "R7 den widths missing", q_dwid.size(), 0);
        chk(q_dcnt.size() == 0, "R7 den counts missing", q_dcnt.size(), 0);
        chk(q_mod.size() == 0, "R8/R9 ac_mod toggles missing", q_mod.size(), 0);
        if (mm && (mp + 1) > vl)
            chk(mod_chg == 0, "R9 no toggle when count exceeds frame", mod_chg, 0);
    endtask

    initial begin
        // R8 frame mode, falling-edge data, divide by 4
        run_cfg(1, 0, 0, 0, 0, 2, 3, 8, 2, 1, 2, 4, 1, 4, "cfgA");
        // R9 line mode, 8 lines per frame, toggle every 3 pulses: frame restart gives a 5-line gap
        run_cfg(0, 0, 1, 1, 2, 2, 3, 8, 2, 1, 2, 4, 1, 4, "cfgB");
        // R3 bypass with a toggle on every line
        run_cfg(0, 1, 0, 1, 0, 2, 3, 8, 2, 1, 2, 4, 1, 4, "cfgC");
        // R10 zero-width porches count as one, rising edge, divide by 6
        run_cfg(2, 0, 1, 1, 4, 1, 1, 5, 0, 2, 0, 3, 1, 4, "cfgD_R10");
        // R9 count larger than the frame: no toggle ever
        run_cfg(1, 0, 0, 1, 9, 2, 3, 8, 2, 1, 2, 4, 1, 3, "cfgE");
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule